// File: doc/BRIEF.md
# Eight-bit ALU with status-flag register

This block is the arithmetic and logic core of a small 8-bit processor datapath. It takes two operand bytes and a 5-bit operation code, and in the same cycle gives the result byte, an optional second result byte, write enables for both, and the status byte that would follow the operation. The status byte is held in a register inside the block. It loads the next value on a clock edge only when the execute strobe is high.

Each operation updates its own subset of the status flags. Flags outside that subset keep their registered value. Carry and borrow inputs come from the registered C bit.

The status byte is laid out as follows:

| Bit | Flag | Meaning |
|-----|------|---------|
| 0 | C | carry / borrow |
| 1 | Z | zero |
| 2 | N | negative |
| 3 | V | two's-complement overflow |
| 4 | S | sign, N XOR V |
| 5 | H | half carry |
| 6 | T | never set by this block |
| 7 | I | never set by this block |

The register file, instruction decode and program sequencing lie outside the block. The caller steers `res_lo` to the destination register and `res_hi` to the register after it.

Top module: `alu8_core`

## Requirements
- R1: A synchronous reset clears the status register `flags_q` to 0x00. On a clock edge with `exec_en` high, `flags_q` loads `flags_next`; with `exec_en` low it keeps its value.
- R2: Add (op 0) and add-with-carry (op 1) compute A+B, plus C for op 1, and write the result. C is bit 8 of the sum. H is the carry out of bit 3, counting the carry input. V is set when A and B have the same sign and the result sign differs. N is result bit 7, S = N XOR V, Z = (result == 0).
- R3: Subtract (op 2), subtract-with-carry (op 3) and compare (op 4) compute A−B, minus C for op 3. C is set when the full difference is negative and H on a borrow out of the low nibble. V is set when the operand signs differ and the result sign differs from A. N, S and Z follow R2. Compare drives the difference on `res_lo` but leaves `res_wr` low.
- R4: AND (op 5), OR (op 6) and XOR (op 7) write A op B. Test (op 8) drives A on `res_lo` and writes nothing. All four clear C, V and H, set N and Z from the value, and set S = N.
- R5: Increment (op 9) and decrement (op 10) write A±1. They update only V, N, S and Z; C and H keep their registered value. V is set when A is 0x7F for increment, or 0x80 for decrement.
- R6: Shift left (op 13) and shift right (op 14) fill with 0 and clear H. Shift left takes C from old bit 7 and sets V = N XOR C. Shift right takes C from old bit 0, clears N and sets V = C.
- R7: Rotate left (op 15) and rotate right (op 16) pass through C. The new C is the bit shifted out, V and H are cleared, N comes from result bit 7, and S = N.
- R8: Complement (op 11) writes ~A, sets C, clears V and H, and sets N, Z and S from the result. Negate (op 12) writes 0−A with all six flags as for the subtraction 0−A.
- R9: Nibble swap (op 17) writes A with its two nibbles exchanged and leaves every status bit unchanged.
- R10: Clear (op 18) writes 0x00 and gives flags with only Z set among H,S,V,N,Z,C. Set-all (op 19) writes 0xFF with N and S set and H, V, Z, C clear.
- R11: Multiply (op 20) drives the low product byte on `res_lo` and the high byte on `res_hi`, with both enables high. It sets Z when the product is zero, sets C when the high byte is non-zero, clears H, and keeps S, V and N.
- R12: Divide (op 21) with a non-zero divisor drives the quotient on `res_lo` and the remainder on `res_hi`, with both enables high. It sets Z when the quotient is zero, clears C, V and H, and keeps N and S. With a divisor of 0 it writes 0x00 through `res_lo` only, sets C and Z, and keeps the other flags.
- R13: `res_hi` is 0x00 and `hi_wr` is low for every operation other than 20 and 21. Codes 22 to 31 write nothing, drive 0x00 on `res_lo`, and leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe; commits `flags_next` to the status register |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First operand (destination value) |
| opnd_b | input | 8 | Second operand or immediate |
| res_lo | output | 8 | Result byte for the destination |
| res_hi | output | 8 | High product byte or remainder |
| res_wr | output | 1 | Write enable for `res_lo` |
| hi_wr | output | 1 | Write enable for `res_hi` |
| flags_next | output | 8 | Status value after this operation |
| flags_q | output | 8 | Registered status value |

## Verification
The bench builds the block with its default width of 8 bits. At that width every flag rule can be hit with hand-picked bytes: the 0x7F/0x80 overflow edges, borrow out of the low nibble, the full 0xFF×0xFF product and division by zero. Each table entry first forces C to a known value with a clear or complement step. This shows both the carry-in path and which flags an operation keeps from the registered status.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_TST  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_COM  = 5'd11,
        OP_NEG  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_SWAP = 5'd17,
        OP_CLR  = 5'd18,
        OP_SER  = 5'd19,
        OP_MUL  = 5'd20,
        OP_DIV  = 5'd21
    } alu_op_t;

    // Status bit positions
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    // Update masks per operation class
    localparam logic [7:0] MSK_ARITH = 8'h3F;  // H S V N Z C
    localparam logic [7:0] MSK_VNSZ  = 8'h1E;  // S V N Z
    localparam logic [7:0] MSK_MUL   = 8'h23;  // H Z C
    localparam logic [7:0] MSK_DIV   = 8'h2B;  // H V Z C
    localparam logic [7:0] MSK_DIV0  = 8'h03;  // Z C
    localparam logic [7:0] MSK_NONE  = 8'h00;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c,
    output logic         h,
    output logic         v
);
    localparam int NIB = W / 2;

    logic [W:0]   full;
    logic [NIB:0] low;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        end
        r = full[W-1:0];
        c = full[W];
        h = low[NIB];
        if (sub)
            v = (a[W-1] ^ b[W-1]) & (a[W-1] ^ full[W-1]);
        else
            v = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ full[W-1]);
    end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] inc_r,
    output logic [W-1:0] dec_r,
    output logic         inc_ovf,
    output logic         dec_ovf,
    output logic [W-1:0] lsl_r,
    output logic [W-1:0] lsr_r,
    output logic [W-1:0] rol_r,
    output logic [W-1:0] ror_r,
    output logic [W-1:0] swp_r
);
    localparam int NIB = W / 2;
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    assign inc_r   = a + {{(W-1){1'b0}}, 1'b1};
    assign dec_r   = a - {{(W-1){1'b0}}, 1'b1};
    assign inc_ovf = (a == POS_MAX);
    assign dec_ovf = (a == NEG_MIN);
    assign lsl_r   = {a[W-2:0], 1'b0};
    assign lsr_r   = {1'b0, a[W-1:1]};
    assign rol_r   = {a[W-2:0], cin};
    assign ror_r   = {cin, a[W-1:1]};
    assign swp_r   = {a[NIB-1:0], a[W-1:NIB]};
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         div_zero
);
    logic [2*W-1:0] prod;

    assign prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign prod_lo  = prod[W-1:0];
    assign prod_hi  = prod[2*W-1:W];
    assign div_zero = (b == '0);
    assign quo      = div_zero ? '0 : a / b;
    assign rem      = div_zero ? '0 : a % b;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exec_en,
    input  logic [4:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi,
    output logic         res_wr,
    output logic         hi_wr,
    output logic [7:0]   flags_next,
    output logic [7:0]   flags_q
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    alu_op_t op;
    assign op = alu_op_t'(op_sel);

    logic c_q;
    assign c_q = flags_q[FL_C];

    // adder / subtractor operand steering
    logic [W-1:0] as_a, as_b, as_r;
    logic         as_cin, as_sub, as_c, as_h, as_v;

    always_comb begin
        as_a   = opnd_a;
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = c_q;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC: begin
                as_sub = 1'b1;
                as_cin = c_q;
            end
            OP_NEG: begin
                as_sub = 1'b1;
                as_a   = '0;
                as_b   = opnd_a;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .r(as_r), .c(as_c), .h(as_h), .v(as_v)
    );

    logic [W-1:0] inc_r, dec_r, lsl_r, lsr_r, rol_r, ror_r, swp_r;
    logic         inc_ovf, dec_ovf;

    alu8_unary #(.W(W)) u_unary (
        .a(opnd_a), .cin(c_q),
        .inc_r(inc_r), .dec_r(dec_r), .inc_ovf(inc_ovf), .dec_ovf(dec_ovf),
        .lsl_r(lsl_r), .lsr_r(lsr_r), .rol_r(rol_r), .ror_r(ror_r), .swp_r(swp_r)
    );

    logic [W-1:0] prod_lo, prod_hi, quo, rem;
    logic         div_zero;

    alu8_muldiv #(.W(W)) u_muldiv (
        .a(opnd_a), .b(opnd_b),
        .prod_lo(prod_lo), .prod_hi(prod_hi), .quo(quo), .rem(rem),
        .div_zero(div_zero)
    );

    // operation select: result, enables, flag values and update mask
    logic [W-1:0] r_sel;
    logic [7:0]   msk;
    logic         cv, hv, vv, nv, zv;

    always_comb begin
        r_sel  = '0;
        res_hi = '0;
        res_wr = 1'b0;
        hi_wr  = 1'b0;
        msk    = MSK_NONE;
        cv = 1'b0; hv = 1'b0; vv = 1'b0; nv = 1'b0; zv = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
                r_sel  = as_r;
                res_wr = (op != OP_CMP);
                msk    = MSK_ARITH;
                cv = as_c; hv = as_h; vv = as_v;
                nv = as_r[W-1]; zv = (as_r == '0);
            end
            OP_AND, OP_OR, OP_XOR, OP_TST: begin
                case (op)
                    OP_AND:  r_sel = opnd_a & opnd_b;
                    OP_OR:   r_sel = opnd_a | opnd_b;
                    OP_XOR:  r_sel = opnd_a ^ opnd_b;
                    default: r_sel = opnd_a;
                endcase
                res_wr = (op != OP_TST);
                msk    = MSK_ARITH;
                nv = r_sel[W-1]; zv = (r_sel == '0);
            end
            OP_INC, OP_DEC: begin
                r_sel  = (op == OP_INC) ? inc_r : dec_r;
                res_wr = 1'b1;
                msk    = MSK_VNSZ;
                vv = (op == OP_INC) ? inc_ovf : dec_ovf;
                nv = r_sel[W-1]; zv = (r_sel == '0);
            end
            OP_COM: begin
                r_sel  = ~opnd_a;
                res_wr = 1'b1;
                msk    = MSK_ARITH;
                cv = 1'b1;
                nv = r_sel[W-1]; zv = (r_sel == '0);
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR: begin
                case (op)
                    OP_LSL:  begin r_sel = lsl_r; cv = opnd_a[W-1]; end
                    OP_LSR:  begin r_sel = lsr_r; cv = opnd_a[0];   end
                    OP_ROL:  begin r_sel = rol_r; cv = opnd_a[W-1]; end
                    default: begin r_sel = ror_r; cv = opnd_a[0];   end
                endcase
                res_wr = 1'b1;
                msk    = MSK_ARITH;
                nv = r_sel[W-1]; zv = (r_sel == '0);
                if (op == OP_LSL || op == OP_LSR)
                    vv = r_sel[W-1] ^ cv;
            end
            OP_SWAP: begin
                r_sel  = swp_r;
                res_wr = 1'b1;
            end
            OP_CLR: begin
                res_wr = 1'b1;
                msk    = MSK_ARITH;
                zv = 1'b1;
            end
            OP_SER: begin
                r_sel  = ALL_ONES;
                res_wr = 1'b1;
                msk    = MSK_ARITH;
                nv = 1'b1;
            end
            OP_MUL: begin
                r_sel  = prod_lo;
                res_hi = prod_hi;
                res_wr = 1'b1;
                hi_wr  = 1'b1;
                msk    = MSK_MUL;
                zv = (prod_lo == '0) && (prod_hi == '0);
                cv = (prod_hi != '0);
            end
            OP_DIV: begin
                res_wr = 1'b1;
                if (div_zero) begin
                    msk = MSK_DIV0;
                    cv = 1'b1; zv = 1'b1;
                end else begin
                    r_sel  = quo;
                    res_hi = rem;
                    hi_wr  = 1'b1;
                    msk    = MSK_DIV;
                    zv = (quo == '0);
                end
            end
            default: ;
        endcase
    end

    assign res_lo = r_sel;

    // merge: masked flags take new values, the rest keep the register
    logic [7:0] fl_val;
    assign fl_val = {2'b00, hv, nv ^ vv, vv, nv, zv, cv};
    assign flags_next = (flags_q & ~msk) | (fl_val & msk);

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= 8'h00;
        else if (exec_en)
            flags_q <= flags_next;
    end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       exec_en,
    input logic [4:0] op_sel,
    input logic [7:0] res_lo,
    input logic       res_wr,
    input logic       hi_wr,
    input logic [7:0] flags_next,
    input logic [7:0] flags_q
);
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(flags_q));

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        exec_en |=> flags_q == $past(flags_next));

    assert_zero_add_R2: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ADD) |-> flags_next[FL_Z] == (res_lo == 8'h00));

    assert_cmp_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_CMP || op_sel == OP_TST) |-> !res_wr);

    assert_keep_ch_R5: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_INC || op_sel == OP_DEC) |->
            (flags_next[FL_C] == flags_q[FL_C]) && (flags_next[FL_H] == flags_q[FL_H]));

    assert_swap_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SWAP) |-> flags_next == flags_q);

    assert_hi_only_muldiv_R13: assert property (@(posedge clk) disable iff (rst)
        hi_wr |-> (op_sel == OP_MUL || op_sel == OP_DIV));
endmodule

bind alu8_core alu8_chk u_chk (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
    .res_lo(res_lo), .res_wr(res_wr), .hi_wr(hi_wr),
    .flags_next(flags_next), .flags_q(flags_q)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_en = 1'b0;
    logic [4:0] op_sel = 5'd0;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [7:0] res_lo, res_hi, flags_next, flags_q;
    logic       res_wr, hi_wr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_lo(res_lo), .res_hi(res_hi),
        .res_wr(res_wr), .hi_wr(hi_wr), .flags_next(flags_next), .flags_q(flags_q)
    );

    // {op, a, b, preset C, res_lo, res_wr, res_hi, hi_wr, flags}
    localparam int NV = 38;
    localparam logic [47:0] VEC [NV] = '{
        {5'd0,  8'h0F, 8'h01, 1'b0, 8'h10, 1'b1, 8'h00, 1'b0, 8'h20}, // R2 half carry
        {5'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 1'b1, 8'h00, 1'b0, 8'h2C}, // R2 overflow
        {5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 8'h23}, // R2 carry, zero
        {5'd1,  8'h10, 8'h20, 1'b1, 8'h31, 1'b1, 8'h00, 1'b0, 8'h00}, // R2 carry in
        {5'd1,  8'h0F, 8'h00, 1'b1, 8'h10, 1'b1, 8'h00, 1'b0, 8'h20}, // R2 carry in to H
        {5'd2,  8'h05, 8'h03, 1'b0, 8'h02, 1'b1, 8'h00, 1'b0, 8'h00}, // R3
        {5'd2,  8'h03, 8'h05, 1'b0, 8'hFE, 1'b1, 8'h00, 1'b0, 8'h35}, // R3 borrow
        {5'd2,  8'h80, 8'h01, 1'b0, 8'h7F, 1'b1, 8'h00, 1'b0, 8'h38}, // R3 overflow
        {5'd3,  8'h10, 8'h10, 1'b1, 8'hFF, 1'b1, 8'h00, 1'b0, 8'h35}, // R3 borrow in
        {5'd4,  8'h42, 8'h42, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h02}, // R3 compare
        {5'd5,  8'hF0, 8'h8F, 1'b1, 8'h80, 1'b1, 8'h00, 1'b0, 8'h14}, // R4 and
        {5'd6,  8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, 8'h02}, // R4 or
        {5'd7,  8'hAA, 8'h55, 1'b0, 8'hFF, 1'b1, 8'h00, 1'b0, 8'h14}, // R4 xor
        {5'd8,  8'h00, 8'h77, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 8'h02}, // R4 test
        {5'd9,  8'h7F, 8'h00, 1'b1, 8'h80, 1'b1, 8'h00, 1'b0, 8'h0D}, // R5 inc ovf
        {5'd9,  8'hFF, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 8'h02}, // R5 inc wrap
        {5'd10, 8'h80, 8'h00, 1'b1, 8'h7F, 1'b1, 8'h00, 1'b0, 8'h19}, // R5 dec ovf
        {5'd10, 8'h01, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 8'h02}, // R5 dec zero
        {5'd11, 8'h0F, 8'h00, 1'b0, 8'hF0, 1'b1, 8'h00, 1'b0, 8'h15}, // R8 com
        {5'd12, 8'h01, 8'h00, 1'b0, 8'hFF, 1'b1, 8'h00, 1'b0, 8'h35}, // R8 neg
        {5'd12, 8'h80, 8'h00, 1'b0, 8'h80, 1'b1, 8'h00, 1'b0, 8'h0D}, // R8 neg 0x80
        {5'd12, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, 8'h02}, // R8 neg 0
        {5'd13, 8'h81, 8'h00, 1'b0, 8'h02, 1'b1, 8'h00, 1'b0, 8'h19}, // R6 lsl
        {5'd13, 8'h40, 8'h00, 1'b1, 8'h80, 1'b1, 8'h00, 1'b0, 8'h0C}, // R6 lsl
        {5'd14, 8'h01, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 8'h1B}, // R6 lsr
        {5'd15, 8'h80, 8'h00, 1'b1, 8'h01, 1'b1, 8'h00, 1'b0, 8'h01}, // R7 rol
        {5'd16, 8'h01, 8'h00, 1'b1, 8'h80, 1'b1, 8'h00, 1'b0, 8'h15}, // R7 ror
        {5'd16, 8'h01, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 8'h03}, // R7 ror
        {5'd17, 8'h3C, 8'h00, 1'b1, 8'hC3, 1'b1, 8'h00, 1'b0, 8'h15}, // R9 swap
        {5'd18, 8'h55, 8'h00, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, 8'h02}, // R10 clr
        {5'd19, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 8'h00, 1'b0, 8'h14}, // R10 ser
        {5'd20, 8'h10, 8'h10, 1'b0, 8'h00, 1'b1, 8'h01, 1'b1, 8'h01}, // R11 mul
        {5'd20, 8'h00, 8'h37, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1, 8'h16}, // R11 mul zero
        {5'd20, 8'hFF, 8'hFF, 1'b0, 8'h01, 1'b1, 8'hFE, 1'b1, 8'h01}, // R11 mul max
        {5'd21, 8'd100, 8'd7, 1'b1, 8'h0E, 1'b1, 8'h02, 1'b1, 8'h14}, // R12 div
        {5'd21, 8'h03, 8'h09, 1'b0, 8'h00, 1'b1, 8'h03, 1'b1, 8'h02}, // R12 div q=0
        {5'd21, 8'h55, 8'h00, 1'b1, 8'h00, 1'b1, 8'h00, 1'b0, 8'h17}, // R12 div by 0
        {5'd31, 8'h01, 8'h02, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 8'h15}  // R13 unused code
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one operation: drive after negedge, sample combinational, commit at posedge
    task automatic step(input logic [4:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic en);
        @(negedge clk);
        op_sel  = op;
        opnd_a  = a;
        opnd_b  = b;
        exec_en = en;
        #1;
    endtask

    task automatic commit();
        @(posedge clk);
        #1;
        exec_en = 1'b0;
    endtask

    task automatic preset_c(input logic c);
        if (c) step(5'd11, 8'h00, 8'h00, 1'b1);   // complement of 0: flags 0x15
        else   step(5'd18, 8'h00, 8'h00, 1'b1);   // clear: flags 0x02
        commit();
    endtask

    initial begin
        string rq;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1", "status after reset", flags_q, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            rq = $sformatf("vector %0d op %0d", i, v[47:43]);
            preset_c(v[26]);
            step(v[47:43], v[42:35], v[34:27], 1'b1);
            chk(rq, "res_lo", res_lo, v[25:18]);
            chk(rq, "res_wr", {7'd0, res_wr}, {7'd0, v[17]});
            chk(rq, "res_hi", res_hi, v[16:9]);
            chk(rq, "hi_wr", {7'd0, hi_wr}, {7'd0, v[8]});
            chk(rq, "flags_next", flags_next, v[7:0]);
            commit();
            chk(rq, "flags_q", flags_q, v[7:0]);
        end

        // R1: strobe low leaves the status untouched
        preset_c(1'b0);
        step(5'd0, 8'hFF, 8'h01, 1'b0);
        chk("R1", "flags_next with strobe low", flags_next, 8'h23);
        @(posedge clk);
        #1;
        chk("R1", "status held with strobe low", flags_q, 8'h02);

        // R2: carry-in comes from the registered C, chained add
        preset_c(1'b1);
        step(5'd1, 8'hFF, 8'h00, 1'b1);
        chk("R2", "adc 0xFF+0+C res", res_lo, 8'h00);
        commit();
        chk("R2", "adc 0xFF+0+C flags", flags_q, 8'h23);
        step(5'd1, 8'h00, 8'h00, 1'b1);
        chk("R2", "adc chained carry", res_lo, 8'h01);
        commit();

        // R5: increment keeps C and H from a prior add
        step(5'd0, 8'h0F, 8'hF1, 1'b1);   // 0x100: C,H,Z set -> 0x23
        commit();
        step(5'd9, 8'h10, 8'h00, 1'b1);
        chk("R5", "inc keeps C and H", flags_next, 8'h21);
        commit();

        // R1: reset clears a non-zero status
        chk("R1", "status before reset", flags_q, 8'h21);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1", "status cleared by reset", flags_q, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule